// File: doc/BRIEF.md
# Tone Transceiver Host Status Interface

This block is the host-facing side of a dual-tone signalling transceiver. A host processor reaches it over a 4-bit asynchronous bus with active-low chip select, read strobe and write strobe, plus one register-select line. Register select low picks the data path: reads return the last received tone code and writes load a new transmit code. Register select high picks the status/control path: reads return the status flags and writes set the control bits.

The status word has four flags. A transmitter-ready flag (bit 1) and a receive-full flag (bit 2) are set by event inputs from the tone engines. An interrupt flag (bit 0) summarises them. A quiet-line flag (bit 3) tracks the steering state of the detector. The first three clear when the host finishes a status read. The quiet-line flag follows only the detector's absence and presence events. An open-drain style interrupt output asks the host for service. The strobes are asynchronous to the system clock. They pass through synchronisers, and edge detection turns them into single-cycle access pulses.

Top module: `tone_host_port`

## Requirements
- R1: After reset, the status word reads 0, `tx_code` is 0, `bus_oe` is 0, `bus_o` is 0 and `irq_drive_low` is 0.
- R2: `bus_oe` is 1 exactly while `cs_n` and `rd_n` are both low. During such a read, `bus_o` carries the last received code when `rsel` is 0 and the status word when `rsel` is 1. Otherwise `bus_o` is 0.
- R3: A write with `rsel` 0 (`cs_n` and `wr_n` low) loads `bus_i` into `tx_code` and pulses `tx_load` for exactly one cycle. A write strobe while `cs_n` is high changes nothing.
- R4: A write with `rsel` 1 sets the control bits: bus bit 0 is the interrupt enable and bus bit 1 is the burst enable (1 = burst mode). Both are 0 after reset.
- R5: A `rx_evt` pulse stores `rx_code` as the received code and sets status bit 2. A data read does not clear bit 2. A completed status read clears it.
- R6: A `tx_evt` pulse sets status bit 1 only while burst mode is enabled. Bit 1 is held at 0 whenever burst mode is off, and it clears after a status read.
- R7: Status bit 0 is set whenever bit 1 or bit 2 gets set. It clears after a status read, and it is not cleared by leaving burst mode.
- R8: A `tone_absent` pulse sets status bit 3 and a `tone_present` pulse clears it. If both arrive together, present wins. Status reads never change bit 3.
- R9: The clear takes effect when the read strobe is released. It acts only on flags that were set when the read began, so a flag set during the read survives it.
- R10: An event in the same cycle as the clearing step wins, and its flag stays set.
- R11: `irq_drive_low` is 1 exactly when status bit 0 is set and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rsel | input | 1 | Register select: 0 data, 1 status/control |
| bus_i | input | 4 | Data from host |
| bus_o | output | 4 | Data to host |
| bus_oe | output | 1 | Output enable for the host bus |
| irq_drive_low | output | 1 | Pull-down enable of the open-drain interrupt line |
| tx_code | output | 4 | Transmit tone code |
| tx_load | output | 1 | One-cycle pulse when a new transmit code is written |
| rx_code | input | 4 | Code from the detector |
| rx_evt | input | 1 | Detector has a valid new code |
| tx_evt | input | 1 | Transmitter pause ended, ready for data |
| tone_absent | input | 1 | Detector validated absence of tone |
| tone_present | input | 1 | Detector validated a tone |

## Verification
The hardest case to reach is an event that lands in the exact clock cycle where the synchronised read release applies the clear. That cycle lies several clocks after the pin edge, counting the synchroniser and edge-detect stages. The stimulus releases `rd_n` on a falling clock edge and counts two more falling edges before it pulses `rx_evt`, so the event lines up with the clear pulse. A second case fires an event after the read's start snapshot but before release, to show that a flag the host never saw is kept.

// File: rtl/thp_pkg.sv
package thp_pkg;
    localparam int ST_W      = 4;
    localparam int ST_IRQ    = 0;
    localparam int ST_TXRDY  = 1;
    localparam int ST_RXFULL = 2;
    localparam int ST_QUIET  = 3;
    localparam int CLR_W     = 3;

    typedef struct packed {
        logic             irq;
        logic             tx;
        logic             rx;
        logic             quiet;
        logic [CLR_W-1:0] mask;
    } flag_state_t;
endpackage

// File: rtl/thp_strobe_sync.sv
module thp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_start,
    output logic rd_end,
    output logic wr_start,
    output logic wr_end
);
    localparam int DEPTH = STAGES + 1;
    localparam int CUR   = STAGES - 1;
    localparam int PRV   = STAGES;

    // bit 2 cs_n, bit 1 rd_n, bit 0 wr_n
    typedef struct packed {
        logic [DEPTH-1:0][2:0] pipe;
    } sync_state_t;

    sync_state_t s_d, s_q;
    logic rd_now, rd_prv, wr_now, wr_prv;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = {cs_n, rd_n, wr_n};
        for (int i = 1; i < DEPTH; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        rd_now   = ~s_q.pipe[CUR][2] & ~s_q.pipe[CUR][1];
        rd_prv   = ~s_q.pipe[PRV][2] & ~s_q.pipe[PRV][1];
        wr_now   = ~s_q.pipe[CUR][2] & ~s_q.pipe[CUR][0];
        wr_prv   = ~s_q.pipe[PRV][2] & ~s_q.pipe[PRV][0];
        rd_start = rd_now & ~rd_prv;
        rd_end   = ~rd_now & rd_prv;
        wr_start = wr_now & ~wr_prv;
        wr_end   = ~wr_now & wr_prv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    AST_RD_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start); // R9
endmodule

// File: rtl/thp_status_flags.sv
module thp_status_flags
    import thp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_evt,
    input  logic            rx_evt,
    input  logic            tone_absent,
    input  logic            tone_present,
    input  logic            burst_en,
    input  logic            snap_en,
    input  logic            clr_en,
    output logic [ST_W-1:0] status
);
    flag_state_t f_d, f_q;
    logic             tx_set;
    logic [CLR_W-1:0] clr;

    always_comb begin
        f_d    = f_q;
        tx_set = tx_evt & burst_en;
        clr    = clr_en ? f_q.mask : '0;
        if (snap_en) f_d.mask = {f_q.rx, f_q.tx, f_q.irq};
        f_d.tx  = burst_en & (tx_set | (f_q.tx & ~clr[ST_TXRDY]));
        f_d.rx  = rx_evt | (f_q.rx & ~clr[ST_RXFULL]);
        f_d.irq = tx_set | rx_evt | (f_q.irq & ~clr[ST_IRQ]);
        if (tone_present)     f_d.quiet = 1'b0;
        else if (tone_absent) f_d.quiet = 1'b1;
        status = '0;
        status[ST_IRQ]    = f_q.irq;
        status[ST_TXRDY]  = f_q.tx;
        status[ST_RXFULL] = f_q.rx;
        status[ST_QUIET]  = f_q.quiet;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    AST_RX_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> status[ST_RXFULL]); // R10
    AST_TX_NONBURST: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> !status[ST_TXRDY]); // R6
    AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[ST_TXRDY]) || $rose(status[ST_RXFULL])) |-> status[ST_IRQ]); // R7
    AST_QUIET_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !tone_absent && !tone_present) |=> $stable(status[ST_QUIET])); // R8
endmodule

// File: rtl/tone_host_port.sv
module tone_host_port
    import thp_pkg::*;
#(
    parameter int DATA_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rsel,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe,
    output logic              irq_drive_low,
    output logic [DATA_W-1:0] tx_code,
    output logic              tx_load,
    input  logic [DATA_W-1:0] rx_code,
    input  logic              rx_evt,
    input  logic              tx_evt,
    input  logic              tone_absent,
    input  logic              tone_present
);
    localparam int CTRL_IEN   = 0;
    localparam int CTRL_BURST = 1;

    typedef struct packed {
        logic [DATA_W-1:0] tx_code;
        logic              tx_load;
        logic [DATA_W-1:0] wr_hold;
        logic              wr_sel;
        logic              rd_sel;
        logic              irq_en;
        logic              burst_en;
        logic [DATA_W-1:0] rx_data;
    } port_state_t;

    port_state_t p_d, p_q;
    logic rd_start, rd_end, wr_start, wr_end;
    logic snap_en, clr_en;
    logic [ST_W-1:0] status;

    thp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .rd_start (rd_start),
        .rd_end   (rd_end),
        .wr_start (wr_start),
        .wr_end   (wr_end)
    );

    thp_status_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_evt       (tx_evt),
        .rx_evt       (rx_evt),
        .tone_absent  (tone_absent),
        .tone_present (tone_present),
        .burst_en     (p_q.burst_en),
        .snap_en      (snap_en),
        .clr_en       (clr_en),
        .status       (status)
    );

    always_comb begin
        p_d         = p_q;
        p_d.tx_load = 1'b0;
        if (rx_evt)   p_d.rx_data = rx_code;
        if (rd_start) p_d.rd_sel  = rsel;
        if (wr_start) begin
            p_d.wr_hold = bus_i;
            p_d.wr_sel  = rsel;
        end
        if (wr_end) begin
            if (!p_q.wr_sel) begin
                p_d.tx_code = p_q.wr_hold;
                p_d.tx_load = 1'b1;
            end else begin
                p_d.irq_en   = p_q.wr_hold[CTRL_IEN];
                p_d.burst_en = p_q.wr_hold[CTRL_BURST];
            end
        end
        snap_en = rd_start & rsel;
        clr_en  = rd_end & p_q.rd_sel;
        bus_oe  = ~cs_n & ~rd_n;
        if (!bus_oe)   bus_o = '0;
        else if (rsel) bus_o = DATA_W'(status);
        else           bus_o = p_q.rx_data;
        irq_drive_low = status[ST_IRQ] & p_q.irq_en;
        tx_code       = p_q.tx_code;
        tx_load       = p_q.tx_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    AST_TX_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load); // R3
    AST_LOAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(wr_end)); // R3
endmodule

// File: tb/tone_host_port_test.sv
module tone_host_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rsel = 1'b0;
    logic [3:0] bus_i = '0, rx_code = '0;
    logic rx_evt = 0, tx_evt = 0, tone_absent = 0, tone_present = 0;
    logic [3:0] bus_o, tx_code;
    logic bus_oe, irq_drive_low, tx_load;
    int n_chk = 0, n_bad = 0, load_cnt = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    tone_host_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .rsel(rsel), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
        .irq_drive_low(irq_drive_low), .tx_code(tx_code), .tx_load(tx_load),
        .rx_code(rx_code), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .tone_absent(tone_absent), .tone_present(tone_present)
    );

    always @(posedge clk) if (rst_n && tx_load) load_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic rs, input logic [3:0] v);
        rsel = rs; bus_i = v; cs_n = 0; wr_n = 0;
        tick(6);
        wr_n = 1; cs_n = 1;
        tick(6);
    endtask

    task automatic host_read(input logic rs, output logic [3:0] v);
        rsel = rs; cs_n = 0; rd_n = 0;
        tick(4);
        v = bus_o;
        rd_n = 1; cs_n = 1;
        tick(6);
    endtask

    task automatic pulse_rx(input logic [3:0] c);
        rx_code = c; rx_evt = 1; tick(1); rx_evt = 0;
    endtask

    task automatic t_reset();
        logic [3:0] v;
        check("R1 oe", bus_oe, 0);
        check("R1 bus", bus_o, 0);
        check("R1 irq", irq_drive_low, 0);
        check("R1 tx_code", tx_code, 0);
        host_read(1, v);
        check("R1 status", v, 0);
    endtask

    task automatic t_write();
        host_write(0, 4'h9);
        check("R3 tx_code", tx_code, 9);
        check("R3 load count", load_cnt, 1);
        rsel = 0; bus_i = 4'h3; wr_n = 0; tick(6); wr_n = 1; tick(6);
        check("R3 ignored code", tx_code, 9);
        check("R3 ignored load", load_cnt, 1);
    endtask

    task automatic t_rx();
        logic [3:0] v;
        pulse_rx(4'h6); tick(2);
        rsel = 0; cs_n = 0; rd_n = 0; tick(1);
        check("R2 oe", bus_oe, 1);
        check("R2 data", bus_o, 6);
        rd_n = 1; cs_n = 1; tick(6);
        host_read(1, v);
        check("R5 status after data read", v, 4'b0101);
        host_read(1, v);
        check("R5 R7 cleared", v, 0);
        rsel = 0; rd_n = 0; tick(1);
        check("R2 oe no cs", bus_oe, 0);
        check("R2 bus no cs", bus_o, 0);
        rd_n = 1; tick(2);
    endtask

    task automatic t_tx();
        logic [3:0] v;
        tx_evt = 1; tick(1); tx_evt = 0; tick(2);
        host_read(1, v);
        check("R6 nonburst ignore", v, 0);
        host_write(1, 4'b0010);
        tx_evt = 1; tick(1); tx_evt = 0; tick(2);
        host_read(1, v);
        check("R4 R6 R7 burst set", v, 4'b0011);
        tx_evt = 1; tick(1); tx_evt = 0; tick(2);
        host_write(1, 4'b0000);
        host_read(1, v);
        check("R6 R7 leave burst", v, 4'b0001);
        host_read(1, v);
        check("R7 irq cleared", v, 0);
    endtask

    task automatic t_irq();
        logic [3:0] v;
        host_write(1, 4'b0010);
        pulse_rx(4'h2); tick(2);
        check("R11 disabled", irq_drive_low, 0);
        host_write(1, 4'b0011);
        check("R4 R11 enabled", irq_drive_low, 1);
        host_read(1, v);
        check("R11 after clear", irq_drive_low, 0);
    endtask

    task automatic t_quiet();
        logic [3:0] v;
        tone_absent = 1; tick(1); tone_absent = 0; tick(2);
        host_read(1, v);
        check("R8 set", v, 4'b1000);
        host_read(1, v);
        check("R8 read keeps", v, 4'b1000);
        tone_present = 1; tick(1); tone_present = 0; tick(2);
        host_read(1, v);
        check("R8 cleared", v, 0);
        tone_absent = 1; tick(1); tone_absent = 0; tick(1);
        tone_absent = 1; tone_present = 1; tick(1);
        tone_absent = 0; tone_present = 0; tick(2);
        host_read(1, v);
        check("R8 present wins", v, 0);
    endtask

    task automatic t_late_event();
        logic [3:0] v;
        rsel = 1; cs_n = 0; rd_n = 0; tick(5);
        pulse_rx(4'hA); tick(2);
        rd_n = 1; cs_n = 1; tick(6);
        host_read(1, v);
        check("R9 late flag kept", v, 4'b0101);
        host_read(1, v);
        check("R9 later cleared", v, 0);
    endtask

    task automatic t_same_cycle();
        logic [3:0] v;
        pulse_rx(4'h4); tick(2);
        rsel = 1; cs_n = 0; rd_n = 0; tick(4);
        rd_n = 1; cs_n = 1; tick(2);
        pulse_rx(4'h5); tick(4);
        host_read(1, v);
        check("R10 event wins", v, 4'b0101);
        host_read(0, v);
        check("R5 code stored", v, 5);
        host_read(1, v);
        check("R10 then cleared", v, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(2);
        t_reset();
        t_write();
        t_rx();
        t_tx();
        t_irq();
        t_quiet();
        t_late_event();
        t_same_cycle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule